// File: doc/BRIEF.md
# Serial Configuration Register Access Port

This block lets an external host read and write a bank of 8-bit configuration registers over a four-wire serial link. The host pulls chip select low, clocks in an 8-bit command code and, for a register access, an 8-bit register address followed by a one-bit end marker that must be zero. A write then carries one data byte, which is stored to the addressed register. A read returns the addressed register's contents, MSB first, on the serial output. Two further command codes arm and disarm a write-protect latch. Register writes go through only while the latch is armed.

The serial clock, chip select and data input arrive from pins and are resynchronised into the block's system clock. Input bits are taken on the rising serial clock edge. Output bits change after the falling edge. Each chip-select assertion carries exactly one command. Anything clocked after that command is complete is ignored until chip select goes high again. The register contents are presented on a flat bus for the rest of the chip. The serial output comes with an enable for the pad, so the line floats while the block is not selected.

Top module: `spi_cfg_port`

## Requirements
- R1: After reset every register holds 0x00 and the write-protect latch is disarmed.
- R2: Command code 0x06 arms the write latch and code 0x04 disarms it, taking effect at the 8th bit of the frame.
- R3: Write frame: code 0x02, an 8-bit address, a marker bit of 0 and 8 data bits, all MSB first and taken on rising serial clock edges. When the latch is armed, the data byte is stored to the addressed register once the 25th bit is taken.
- R4: A write frame sent while the latch is disarmed leaves every register unchanged.
- R5: Read frame: code 0x03, an 8-bit address and a marker bit of 0. The register byte then appears MSB first on `spi_miso` and is valid at rising edges 18 through 25. The output is 0 at rising edges 1 through 17.
- R6: A frame whose marker bit is 1 is discarded: a write stores nothing, and a read returns all zeros.
- R7: Only one command is taken per chip-select assertion. Bits clocked after the command completes change no register and no latch state, and `spi_miso` reads 0 after the read byte.
- R8: Raising chip select before a write's 25th bit aborts it with no register change. The next frame is decoded from its first bit as a command code.
- R9: Any command code other than 0x02, 0x03, 0x04 or 0x06 changes neither the latch nor any register.
- R10: Addresses at or above NUM_REGS are dropped on writes and read back as 0x00.
- R11: Register k is presented on `cfg_regs[8k+7:8k]`. The bus changes only as the result of an accepted write.
- R12: `spi_miso_oe` is 0 while `spi_cs_n` is high, so the pad releases the line to high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Pad output enable for `spi_miso` |
| cfg_regs | output | NUM_REGS*8 | Flat register bank contents |

## Verification
Writes are sent with the latch both disarmed and armed, so that a blocked store can be told apart from a completed one. Reads return distinct bit patterns from the low, middle and top registers, which exposes any shift-direction or bit-position error. Frames are then deformed one way at a time: a bad marker bit, trailing extra clocks, chip select raised at bits 20 and 24, an unknown command code, and an out-of-range address. Each deformed frame shows whether the register bus and the latch kept their prior state. A behavioural model of the register bank is compared with the register bus on every idle clock.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [BYTE_W-1:0] {
        OP_ARM    = 8'h06,
        OP_DISARM = 8'h04,
        OP_READ   = 8'h03,
        OP_WRITE  = 8'h02
    } opcode_e;

    typedef enum logic [2:0] {
        PH_CODE,
        PH_ADDR,
        PH_MARK,
        PH_DATA,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic  valid;
        byte_t addr;
        byte_t data;
    } wr_req_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic idle;
        logic din;
    } spi_evt_t;

    function automatic byte_t shift_in(byte_t cur, logic bit_in);
        return {cur[BYTE_W-2:0], bit_in};
    endfunction

endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync
    import spi_cfg_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk,
    input  logic     cs_n,
    input  logic     mosi,
    output spi_evt_t evt
);

    localparam int unsigned TOP = STAGES - 1;

    logic [STAGES-1:0] sclk_s;
    logic [STAGES-1:0] cs_s;
    logic [STAGES-1:0] din_s;
    logic              sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_s    <= '0;
            cs_s      <= '1;
            din_s     <= '0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_s    <= {sclk_s[STAGES-2:0], sclk};
            cs_s      <= {cs_s[STAGES-2:0], cs_n};
            din_s     <= {din_s[STAGES-2:0], mosi};
            sclk_prev <= sclk_s[TOP];
        end
    end

    always_comb begin
        evt.rise = sclk_s[TOP] & ~sclk_prev;
        evt.fall = ~sclk_s[TOP] & sclk_prev;
        evt.idle = cs_s[TOP];
        evt.din  = din_s[TOP];
    end

endmodule

// File: rtl/spi_cfg_ctrl.sv
module spi_cfg_ctrl
    import spi_cfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  spi_evt_t evt,
    input  byte_t    rd_data,
    output byte_t    rd_addr,
    output wr_req_t  wr_req,
    output logic     miso,
    output logic     wren
);

    localparam int unsigned CNT_W = $clog2(BYTE_W);

    phase_e          phase;
    opcode_e         op_q;
    logic [CNT_W-1:0] bit_cnt;
    byte_t           rx_sh;
    byte_t           addr_q;
    byte_t           tx_sh;
    byte_t           rx_next;
    logic            last_bit;
    logic            miso_q;
    logic            wren_q;
    wr_req_t         wr_q;

    assign rx_next  = shift_in(rx_sh, evt.din);
    assign last_bit = (bit_cnt == CNT_W'(BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_CODE;
            op_q    <= OP_DISARM;
            bit_cnt <= '0;
            rx_sh   <= '0;
            addr_q  <= '0;
            tx_sh   <= '0;
            miso_q  <= 1'b0;
            wren_q  <= 1'b0;
            wr_q    <= '0;
        end else begin
            wr_q.valid <= 1'b0;
            if (evt.idle) begin
                phase   <= PH_CODE;
                bit_cnt <= '0;
                tx_sh   <= '0;
                miso_q  <= 1'b0;
            end else begin
                if (evt.rise) begin
                    rx_sh <= rx_next;
                    case (phase)
                        PH_CODE: begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (last_bit) begin
                                bit_cnt <= '0;
                                case (rx_next)
                                    OP_ARM: begin
                                        wren_q <= 1'b1;
                                        phase  <= PH_DONE;
                                    end
                                    OP_DISARM: begin
                                        wren_q <= 1'b0;
                                        phase  <= PH_DONE;
                                    end
                                    OP_READ, OP_WRITE: begin
                                        op_q  <= opcode_e'(rx_next);
                                        phase <= PH_ADDR;
                                    end
                                    default: phase <= PH_DONE;
                                endcase
                            end
                        end
                        PH_ADDR: begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (last_bit) begin
                                bit_cnt <= '0;
                                addr_q  <= rx_next;
                                phase   <= PH_MARK;
                            end
                        end
                        PH_MARK: begin
                            if (evt.din) begin
                                phase <= PH_DONE;
                            end else if (op_q == OP_READ) begin
                                tx_sh <= rd_data;
                                phase <= PH_DONE;
                            end else begin
                                phase <= PH_DATA;
                            end
                        end
                        PH_DATA: begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (last_bit) begin
                                bit_cnt    <= '0;
                                wr_q.valid <= wren_q;
                                wr_q.addr  <= addr_q;
                                wr_q.data  <= rx_next;
                                phase      <= PH_DONE;
                            end
                        end
                        default: ;
                    endcase
                end
                if (evt.fall) begin
                    miso_q <= tx_sh[BYTE_W-1];
                    tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign rd_addr = addr_q;
    assign wr_req  = wr_q;
    assign miso    = miso_q;
    assign wren    = wren_q;

endmodule

// File: rtl/spi_cfg_regbank.sv
module spi_cfg_regbank
    import spi_cfg_pkg::*;
#(
    parameter int unsigned NUM_REGS = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  wr_req_t                    wr_req,
    input  byte_t                      rd_addr,
    output byte_t                      rd_data,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_flat
);

    byte_t regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (wr_req.valid && wr_req.addr == byte_t'(g)) begin
                regs[g] <= wr_req.data;
            end
        end
        assign cfg_flat[g*BYTE_W +: BYTE_W] = regs[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == byte_t'(i)) begin
                rd_data = regs[i];
            end
        end
    end

endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
    import spi_cfg_pkg::*;
#(
    parameter int unsigned NUM_REGS    = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       spi_sclk,
    input  logic                       spi_cs_n,
    input  logic                       spi_mosi,
    output logic                       spi_miso,
    output logic                       spi_miso_oe,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_regs
);

    spi_evt_t evt;
    wr_req_t  wr_req;
    byte_t    rd_addr;
    byte_t    rd_data;
    logic     wren;

    spi_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .sclk (spi_sclk),
        .cs_n (spi_cs_n),
        .mosi (spi_mosi),
        .evt  (evt)
    );

    spi_cfg_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_req  (wr_req),
        .miso    (spi_miso),
        .wren    (wren)
    );

    spi_cfg_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_req   (wr_req),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .cfg_flat (cfg_regs)
    );

    assign spi_miso_oe = ~spi_cs_n;

endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk #(
    parameter int unsigned NUM_REGS = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_valid,
    input logic                  wren,
    input logic                  cs_idle,
    input logic [NUM_REGS*8-1:0] cfg_regs
);

    // R4
    unarmed_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> wren);

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_valid) |-> $stable(cfg_regs));

    // R7
    single_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    // R8
    idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        cs_idle |=> !wr_valid);

endmodule

bind spi_cfg_port spi_cfg_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_req.valid),
    .wren     (wren),
    .cs_idle  (evt.idle),
    .cfg_regs (cfg_regs)
);

// File: tb/test_spi_cfg_port.sv
module test_spi_cfg_port;

    localparam int NUM_REGS = 16;
    localparam int HALF     = 4;
    localparam int FLAT_W   = NUM_REGS * 8;

    typedef bit bitq_t[$];

    logic clk  = 1'b0;
    logic rst  = 1'b1;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic              miso;
    logic              miso_oe;
    logic [FLAT_W-1:0] cfg;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   settled  = 1'b0;
    bit   done     = 1'b0;
    logic [7:0] model_regs [NUM_REGS];
    bit   model_we = 1'b0;

    always #5 clk = ~clk;

    spi_cfg_port #(.NUM_REGS(NUM_REGS)) i_spi_cfg_port (
        .clk         (clk),
        .rst         (rst),
        .spi_sclk    (sclk),
        .spi_cs_n    (cs_n),
        .spi_mosi    (mosi),
        .spi_miso    (miso),
        .spi_miso_oe (miso_oe),
        .cfg_regs    (cfg)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [FLAT_W-1:0] act, input logic [FLAT_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [FLAT_W-1:0] model_flat();
        logic [FLAT_W-1:0] f = '0;
        for (int k = 0; k < NUM_REGS; k++) f[k*8 +: 8] = model_regs[k];
        return f;
    endfunction

    function automatic bitq_t build(input logic [7:0] op, input logic [7:0] ad,
                                    input logic mark, input logic [7:0] dt, input int n);
        bitq_t q;
        for (int i = 7; i >= 0; i--) q.push_back(op[i]);
        for (int i = 7; i >= 0; i--) q.push_back(ad[i]);
        q.push_back(mark);
        for (int i = 7; i >= 0; i--) q.push_back(dt[i]);
        while (q.size() < n) q.push_back(1'b1);
        return q;
    endfunction

    // Per-clock comparison: register bus against model while idle (R11),
    // output enable released while deselected (R12).
    always @(negedge clk) begin
        if (!rst && settled && !done)
            check(cfg === model_flat(), "R11", "register bus vs model", cfg, model_flat());
        if (!rst && cs_n && !done)
            check(miso_oe === 1'b0, "R12", "miso_oe while deselected", FLAT_W'(miso_oe), '0);
    end

    task automatic cmd(input logic [7:0] op, input logic [7:0] ad, input logic mark,
                       input logic [7:0] dt, input int n, input string req);
        bitq_t      b;
        bit         rx[$];
        logic [7:0] exp_rd;
        logic [7:0] rd;
        logic [7:0] tail;
        bit         lead_ok;
        b = build(op, ad, mark, dt, n);
        exp_rd = 8'h00;
        if (op == 8'h03 && n >= 25 && mark == 1'b0 && ad < NUM_REGS)
            exp_rd = model_regs[ad];
        settled = 1'b0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        check(miso_oe === 1'b1, "R12", "miso_oe while selected", FLAT_W'(miso_oe), 1);
        for (int k = 0; k < n; k++) begin
            mosi = b[k];
            repeat (HALF) @(negedge clk);
            rx.push_back(miso);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        if (n >= 8) begin
            if (op == 8'h06) model_we = 1'b1;
            if (op == 8'h04) model_we = 1'b0;
            if (op == 8'h02 && n >= 25 && mark == 1'b0 && model_we && ad < NUM_REGS)
                model_regs[ad] = dt;
        end
        repeat (8) @(negedge clk);
        if (op == 8'h03 && n >= 25) begin
            rd = '0;
            for (int k = 17; k < 25; k++) rd = {rd[6:0], rx[k]};
            lead_ok = 1'b1;
            for (int k = 0; k < 17; k++) if (rx[k]) lead_ok = 1'b0;
            check(rd == exp_rd, req, "read byte", FLAT_W'(rd), FLAT_W'(exp_rd));
            check(lead_ok, req, "output zero before read byte", FLAT_W'(lead_ok), 1);
            if (n >= 33) begin
                tail = '0;
                for (int k = 25; k < 33; k++) tail = {tail[6:0], rx[k]};
                check(tail == 8'h00, "R7", "output after read byte", FLAT_W'(tail), 0);
            end
        end
        check(cfg === model_flat(), req, "register bus after frame", cfg, model_flat());
        settled = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not complete)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NUM_REGS; k++) model_regs[k] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(cfg === '0, "R1", "registers after reset", cfg, '0);
        settled = 1'b1;
        cmd(8'h02, 8'd3, 1'b0, 8'hA5, 25, "R4");
        cmd(8'h03, 8'd3, 1'b0, 8'h00, 25, "R1");
        cmd(8'h06, 8'd0, 1'b0, 8'h00, 8, "R2");
        cmd(8'h02, 8'd3, 1'b0, 8'hA5, 25, "R3");
        check(cfg[31:24] === 8'hA5, "R11", "register 3 field position", FLAT_W'(cfg[31:24]), 8'hA5);
        cmd(8'h03, 8'd3, 1'b0, 8'h00, 25, "R5");
        cmd(8'h02, 8'd15, 1'b0, 8'h3C, 25, "R3");
        cmd(8'h02, 8'd0, 1'b0, 8'h81, 25, "R3");
        cmd(8'h03, 8'd15, 1'b0, 8'h00, 25, "R5");
        cmd(8'h03, 8'd0, 1'b0, 8'h00, 25, "R5");
        cmd(8'h02, 8'd5, 1'b1, 8'hFF, 25, "R6");
        cmd(8'h03, 8'd3, 1'b1, 8'h00, 25, "R6");
        cmd(8'h02, 8'd7, 1'b0, 8'h11, 34, "R7");
        cmd(8'h03, 8'd3, 1'b0, 8'h00, 33, "R7");
        cmd(8'h06, 8'd9, 1'b0, 8'h77, 25, "R7");
        cmd(8'h02, 8'd2, 1'b0, 8'hEE, 20, "R8");
        cmd(8'h02, 8'd2, 1'b0, 8'hEE, 24, "R8");
        cmd(8'h02, 8'd2, 1'b0, 8'h44, 25, "R8");
        cmd(8'h05, 8'd4, 1'b0, 8'h99, 25, "R9");
        cmd(8'hFF, 8'd4, 1'b0, 8'h99, 25, "R9");
        cmd(8'h02, 8'd4, 1'b0, 8'h12, 25, "R9");
        cmd(8'h02, 8'h20, 1'b0, 8'hAB, 25, "R10");
        cmd(8'h03, 8'h20, 1'b0, 8'h00, 25, "R10");
        cmd(8'h04, 8'd0, 1'b0, 8'h00, 8, "R2");
        cmd(8'h02, 8'd3, 1'b0, 8'h00, 25, "R4");
        cmd(8'h03, 8'd3, 1'b0, 8'h00, 25, "R5");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule